// File: doc/BRIEF.md
# Parallel NOR Flash Command Interpreter

This block models the command side of a parallel NOR flash device whose array lives in on-chip memory. A host drives a simple synchronous bus with a write strobe, a read strobe, a byte address and a data word of `DW` bits. The block decodes single-cycle and multi-cycle command sequences written on the bus. The low byte of each write is the command value.

The sequence in progress decides what a read returns. It can be the stored array word, the 8-bit status register, or a byte from a computed device query table. Two command sequences change the array. Sector erase fills one sector with ones, one word per clock, and raises `busy` while it runs. Buffered programming takes a count, then that many words plus one, then a confirm code.

A sequence that the block does not recognise raises a one-cycle `err` pulse and returns the device to array reads. Reads have one cycle of latency: `rdata` changes on the clock edge that samples `rd_en` and then holds until the next read.

Top module: `nor_cmd_flash`

## Requirements
- R1: After reset the block is in array-read mode, the status register is 0x00, and `busy`, `err` and `rdata` are all 0.
- R2: In array-read mode, a read returns the `DW/8` stored bytes that start at the address aligned down to the word size. The lowest address is placed in bits 7:0 (little-endian).
- R3: While the pending sequence is read-status (0x70), erase setup (0x20), lock (0x60) or any step of write-to-buffer (0xE8), or while an erase runs, a read returns the status register zero-extended to `DW`. Bit 7 of the status register is the ready flag.
- R4: Command 0x98 enters query mode. A read in query mode uses index = address[7:0] >> log2(DW/8) and returns that query byte zero-extended. The table holds 0x51, 0x52, 0x59 at indices 0x10 to 0x12, and 0x01, 0x00 at 0x13 and 0x14. Index 0x27 holds log2 of the total bytes and index 0x2C holds 0x01. Indices 0x2D and 0x2E hold (sectors - 1) as low byte then high byte. Indices 0x2F and 0x30 hold the sector size divided by 256 as low byte then high byte. Every other index, and every index of 64 or more, reads 0.
- R5: 0x20 followed by 0xD0 erases the sector that holds the address of the 0xD0 write, setting every byte to 0xFF. `busy` is high for exactly `SECT/(DW/8)` cycles, and status bit 7 reads 0 during that time. When the erase ends, status bit 7 is 1 and reads still return status.
- R6: After 0x20, a second write of 0xFF returns to array mode with no error. Any other value except 0xD0 raises `err` and returns to array mode.
- R7: 0xE8 sets status bit 7. The next write supplies a count N in its low byte. The N+1 writes that follow are each stored at their own address and each sets status bit 7. A following 0xD0 returns to array mode; any other value there raises `err` and returns to array mode.
- R8: After 0x60, a second write of 0xD0 or 0x01 sets status bit 7 and leaves reads returning status, with no change to the array. Any other value returns to array mode without `err`.
- R9: 0x50 sets the status register to 0x00 and returns to array mode.
- R10: 0x70 selects status readback without starting a sequence, so the next write is decoded as a fresh command. Writes of 0x00 or 0xFF in that decoding return to array mode.
- R11: An unrecognised command value written in array mode or read-status mode raises `err` for exactly one cycle and leaves the block in array mode.
- R12: Writes that arrive while `busy` is high have no effect on mode, status or array.
- R13: Query mode is left only by a write of 0xFF. Any other written value is ignored and query reads continue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe; the low byte of `wdata` is the command value |
| rd_en | input | 1 | Read strobe; `rdata` updates on the same edge |
| addr | input | log2(SECT*NSECT) | Byte address into the array |
| wdata | input | DW | Write data or command |
| rdata | output | DW | Registered read data |
| busy | output | 1 | High while a sector erase is in progress |
| err | output | 1 | One-cycle pulse on an unrecognised sequence |

## Verification
The assertions assume that `rd_en` and `wr_en` are never high in the same cycle, so a status read can never see a status change made by a write in that same cycle. They also assume the address is at least eight bits wide, which the query index needs. The stimulus drives one strobe per cycle at most, uses only word-aligned addresses, and runs every sequence from the cycle after reset. A behavioural byte-level model in the bench predicts `busy`, `err` and every read.

// File: rtl/nor_cmd_flash.sv
module nor_cmd_flash #(
  parameter int DW    = 16,
  parameter int SECT  = 256,
  parameter int NSECT = 8
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              wr_en,
  input  logic                              rd_en,
  input  logic [$clog2(SECT*NSECT)-1:0]     addr,
  input  logic [DW-1:0]                     wdata,
  output logic [DW-1:0]                     rdata,
  output logic                              busy,
  output logic                              err
);
  localparam int BPW    = DW / 8;
  localparam int BSH    = $clog2(BPW);
  localparam int SB     = $clog2(SECT);
  localparam int SECW   = $clog2(NSECT);
  localparam int AW     = SB + SECW;
  localparam int WAW    = AW - BSH;
  localparam int PW     = SB - BSH;
  localparam int WORDS  = 1 << WAW;
  localparam int QT_LEN = 64;

  typedef enum logic [3:0] {
    S_ARR, S_STAT, S_QRY, S_ESET, S_ERS, S_LOCK, S_WCNT, S_WDAT, S_WCNF
  } st_t;

  st_t             st;
  logic [7:0]      status;
  logic [7:0]      cnt;
  logic [SECW-1:0] esec;
  logic [PW-1:0]   eptr;
  logic [DW-1:0]   mem [WORDS];

  wire [7:0]     cmd      = wdata[7:0];
  wire           ers_last = &eptr;
  wire           wb_store = wr_en && st == S_WDAT;
  wire [WAW-1:0] widx     = addr[AW-1:BSH];
  wire [7:0]     qidx     = 8'(addr[7:0] >> BSH);

  assign busy = (st == S_ERS);

  function automatic logic [7:0] qbyte(input logic [7:0] i);
    case (i)
      8'h10: qbyte = 8'h51;
      8'h11: qbyte = 8'h52;
      8'h12: qbyte = 8'h59;
      8'h13: qbyte = 8'h01;
      8'h27: qbyte = 8'(AW);
      8'h2C: qbyte = 8'h01;
      8'h2D: qbyte = 8'(NSECT - 1);
      8'h2E: qbyte = 8'((NSECT - 1) >> 8);
      8'h2F: qbyte = 8'(SECT >> 8);
      8'h30: qbyte = 8'(SECT >> 16);
      default: qbyte = 8'h00;
    endcase
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_ARR;
      status <= 8'h00;
      cnt    <= 8'h00;
      esec   <= '0;
      eptr   <= '0;
      err    <= 1'b0;
    end else begin
      err <= 1'b0;
      if (busy) begin
        eptr <= eptr + 1'b1;
        if (ers_last) begin
          st        <= S_STAT;
          status[7] <= 1'b1;
        end
      end else if (wr_en) begin
        case (st)
          S_ARR, S_STAT:
            case (cmd)
              8'h00, 8'hFF: st <= S_ARR;
              8'h20: st <= S_ESET;
              8'h50: begin status <= 8'h00; st <= S_ARR; end
              8'h60: st <= S_LOCK;
              8'h70: st <= S_STAT;
              8'h98: st <= S_QRY;
              8'hE8: begin status[7] <= 1'b1; st <= S_WCNT; end
              default: begin err <= 1'b1; st <= S_ARR; end
            endcase
          S_QRY: if (cmd == 8'hFF) st <= S_ARR;
          S_ESET:
            if (cmd == 8'hD0) begin
              st        <= S_ERS;
              status[7] <= 1'b0;
              esec      <= addr[AW-1:SB];
              eptr      <= '0;
            end else if (cmd == 8'hFF) begin
              st <= S_ARR;
            end else begin
              err <= 1'b1;
              st  <= S_ARR;
            end
          S_LOCK:
            if (cmd == 8'hD0 || cmd == 8'h01) begin
              status[7] <= 1'b1;
              st        <= S_STAT;
            end else begin
              st <= S_ARR;
            end
          S_WCNT: begin cnt <= cmd; st <= S_WDAT; end
          S_WDAT: begin
            status[7] <= 1'b1;
            if (cnt == 8'h00) st <= S_WCNF;
            else cnt <= cnt - 1'b1;
          end
          S_WCNF: begin
            if (cmd != 8'hD0) err <= 1'b1;
            st <= S_ARR;
          end
          default: st <= S_ARR;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (busy) mem[{esec, eptr}] <= '1;
    else if (wb_store) mem[widx] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rdata <= '0;
    else if (rd_en) begin
      case (st)
        S_ARR:   rdata <= mem[widx];
        S_QRY:   rdata <= DW'(qidx < QT_LEN ? qbyte(qidx) : 8'h00);
        default: rdata <= DW'(status);
      endcase
    end
  end

  // R11
  err_from_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> $past(wr_en));

  // R5
  ready_at_erase_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> status[7]);

  // R5
  not_ready_in_erase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !status[7]);

  // R3
  status_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !wr_en && !busy &&
     (st == S_STAT || st == S_ESET || st == S_LOCK ||
      st == S_WCNT || st == S_WDAT || st == S_WCNF))
    |=> rdata == DW'($past(status)));

  // R4
  query_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && st == S_QRY && qidx >= QT_LEN) |=> rdata == '0);
endmodule

// File: tb/nor_cmd_flash_test.sv
`timescale 1ns/1ps
module nor_cmd_flash_test;
  localparam int DW = 16, SECT = 256, NSECT = 8;
  localparam int BPW = DW / 8;
  localparam int TOT = SECT * NSECT;
  localparam int AW = $clog2(TOT);
  localparam int WPS = SECT / BPW;

  logic clk = 0, rst_n = 0, wr_en = 0, rd_en = 0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic busy, err;

  nor_cmd_flash #(.DW(DW), .SECT(SECT), .NSECT(NSECT)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .busy(busy), .err(err));

  always #2.5 clk = ~clk;

  int checks = 0, fails = 0;
  bit done = 0;
  string tag = "R1";

  // model: 0 array,1 status,2 query,3 erase setup,4 erase,5 lock,6 count,7 data,8 confirm
  int mb[TOT];
  int mst = 0, mstat = 0, mcnt = 0, eleft = 0;
  int exp_rd = 0;
  bit exp_known = 1, exp_err = 0;

  function automatic int qref(int i);
    case (i)
      'h10: return 'h51;
      'h11: return 'h52;
      'h12: return 'h59;
      'h13: return 1;
      'h27: return AW;
      'h2C: return 1;
      'h2D: return (NSECT - 1) & 255;
      'h2E: return ((NSECT - 1) >> 8) & 255;
      'h2F: return (SECT >> 8) & 255;
      'h30: return (SECT >> 16) & 255;
      default: return 0;
    endcase
  endfunction

  task automatic model(bit w, bit r, int a, int d);
    int c, base;
    exp_err = 0;
    c = d & 255;
    if (r) begin
      if (mst == 0) begin
        base = a - (a % BPW);
        exp_rd = 0; exp_known = 1;
        for (int i = 0; i < BPW; i++) begin
          if (mb[base+i] < 0) exp_known = 0;
          else exp_rd = exp_rd | (mb[base+i] << (8*i));
        end
      end else if (mst == 2) begin
        exp_rd = qref((a & 255) / BPW); exp_known = 1;
      end else begin
        exp_rd = mstat; exp_known = 1;
      end
    end
    if (mst == 4) begin
      eleft--;
      if (eleft == 0) begin mst = 1; mstat = mstat | 128; end
    end else if (w) begin
      case (mst)
        0, 1: begin
          if (c == 0 || c == 'hFF) mst = 0;
          else if (c == 'h20) mst = 3;
          else if (c == 'h50) begin mstat = 0; mst = 0; end
          else if (c == 'h60) mst = 5;
          else if (c == 'h70) mst = 1;
          else if (c == 'h98) mst = 2;
          else if (c == 'hE8) begin mstat = mstat | 128; mst = 6; end
          else begin exp_err = 1; mst = 0; end
        end
        2: if (c == 'hFF) mst = 0;
        3: begin
          if (c == 'hD0) begin
            mst = 4; eleft = WPS; mstat = mstat & 'h7F;
            base = a - (a % SECT);
            for (int i = 0; i < SECT; i++) mb[base+i] = 255;
          end else if (c == 'hFF) mst = 0;
          else begin exp_err = 1; mst = 0; end
        end
        5: begin
          if (c == 'hD0 || c == 1) begin mstat = mstat | 128; mst = 1; end
          else mst = 0;
        end
        6: begin mcnt = c + 1; mst = 7; end
        7: begin
          base = a - (a % BPW);
          for (int i = 0; i < BPW; i++) mb[base+i] = (d >> (8*i)) & 255;
          mstat = mstat | 128;
          mcnt--;
          if (mcnt == 0) mst = 8;
        end
        8: begin if (c != 'hD0) exp_err = 1; mst = 0; end
        default: mst = 0;
      endcase
    end
  endtask

  task automatic compare();
    checks++;
    if (busy !== (mst == 4)) begin
      fails++;
      $display("FAIL %s busy got %0d expected %0d", tag, busy, mst == 4);
    end
    checks++;
    if (err !== exp_err) begin
      fails++;
      $display("FAIL %s err got %0d expected %0d", tag, err, exp_err);
    end
    if (exp_known) begin
      checks++;
      if (rdata !== DW'(exp_rd)) begin
        fails++;
        $display("FAIL %s rdata got %h expected %h", tag, rdata, DW'(exp_rd));
      end
    end
  endtask

  task automatic step(bit w, bit r, int a, int d);
    @(negedge clk);
    wr_en = w; rd_en = r; addr = AW'(a); wdata = DW'(d);
    model(w, r, a, d);
    @(posedge clk);
    #1;
    compare();
  endtask

  task automatic wr(int a, int d); step(1, 0, a, d); endtask
  task automatic rd(int a); step(0, 1, a, 0); endtask
  task automatic drain();
    while (mst == 4) step(0, 0, 0, 0);
  endtask

  initial begin
    for (int i = 0; i < TOT; i++) mb[i] = -1;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    #1;
    tag = "R1"; compare();
    wr(0, 'h70); rd(0);

    // R5 erase sector 0 via unaligned address, read and write during busy
    tag = "R5"; wr(0, 'h20); wr('h010, 'hD0);
    rd(0); rd(4);
    tag = "R12"; wr(0, 'hFF); wr(0, 'h98);
    tag = "R5"; drain(); rd(0);
    tag = "R12"; rd(2);
    tag = "R5"; wr(0, 'h20); wr('h1F2, 'hD0); drain(); rd('h100);

    // R9
    tag = "R9"; wr(0, 'h50); rd('h10);
    wr(0, 'h70); rd(0);

    // R2 erased words, R7 buffered write
    tag = "R2"; wr(0, 'h00); rd('h0FE); rd('h100);
    tag = "R7"; wr('h100, 'hE8); rd('h100);
    wr('h100, 'h03); rd(0);
    wr('h100, 'hA1B2); wr('h102, 'h0304); wr('h104, 'hFFEE); rd(0); wr('h106, 'h5A00);
    wr('h100, 'hD0);
    tag = "R2"; rd('h100); rd('h102); rd('h104); rd('h106); rd('h108); rd('h012);
    tag = "R7"; wr('h110, 'hE8); wr('h110, 'h00); wr('h110, 'h1234); wr(0, 'h55);
    rd('h110);

    // R6
    tag = "R6"; wr(0, 'h20); wr(0, 'hFF); rd('h100);
    wr(0, 'h20); wr(0, 'h33); rd('h102);

    // R8
    tag = "R8"; wr(0, 'h50); wr(0, 'h60); rd(0);
    wr('h100, 'h01); rd(0); rd('h100);
    wr(0, 'h50); wr(0, 'h60); rd(0); wr(0, 'hD0); rd(0);
    wr(0, 'h60); wr(0, 'h42); rd('h104);

    // R3 status during erase setup, R10 command after 0x70
    tag = "R3"; wr(0, 'h20); rd(0); wr(0, 'hFF);
    tag = "R10"; wr(0, 'h70); rd('h100); wr(0, 'h98); rd('h20);
    wr(0, 'hFF); wr(0, 'h70); wr(0, 'h00); rd('h102);

    // R4 query table, R13 exit only on 0xFF
    tag = "R4"; wr(0, 'h98);
    rd('h20); rd('h22); rd('h24); rd('h26); rd('h28); rd('h4E); rd('h58);
    rd('h5A); rd('h5C); rd('h5E); rd('h60); rd('h7E); rd('h80); rd('hFE); rd('h120);
    tag = "R13"; wr(0, 'h70); rd('h20); wr(0, 'h00); rd('h22); wr(0, 'hFF); rd('h100);

    // R11
    tag = "R11"; wr(0, 'h12); step(0, 0, 0, 0); rd('h104);
    wr(0, 'h70); wr(0, 'hC3); rd('h106);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule